// File: doc/BRIEF.md
# Alternating Serial Bit-String Recogniser

This block watches a serial input, one bit per clock edge, and judges the whole string received since the last reset. It raises its accept output when that string is a single 1, or a 1 followed by any number of `01` pairs: 1, 101, 10101, and so on. The empty string is not accepted.

Once a bit breaks that shape, the machine enters a sink state. It stays there and keeps the output low until the next reset. The block never slides a window over the stream and never recovers by itself. Because it is a Moore machine, the output is decoded from the stored state alone.

The state fits in two bits with an asynchronous active-low reset. A caller pulses reset to start a new judgement and then shifts bits in on the input.

Top module: `alt_pattern_recognizer`

## Requirements
- R1: While rst_ni is low, accept_o is low and the machine is in its start state. This takes effect at once, without waiting for a clock edge.
- R2: From the start state, a 1 on bit_i at a rising edge drives accept_o high after that edge. A 0 moves the machine to the sink, where accept_o is low.
- R3: While accept_o is high, a 0 at the next edge returns the machine to the start state with accept_o low. A 1 moves it to the sink.
- R4: Once in the sink, the machine stays there for any later input until reset, and accept_o stays low.
- R5: After each edge, accept_o is high exactly when the bits received since reset match 1(01)*. Matching bits have odd count, with 1 at even positions and 0 at odd positions, counted from 0.
- R6: accept_o depends only on the stored state. Changing bit_i between clock edges never changes accept_o.
- R7: A reset asserted in the middle of a stream discards all earlier bits, and the next string is judged from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one serial bit is taken per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset to the start state |
| bit_i | input | 1 | Serial data bit |
| accept_o | output | 1 | High while the string received so far has the accepted shape |

## Verification
The assertions assume that bit_i is a defined 0 or 1 at every rising edge while reset is released. They also assume that reset is driven low from time zero, before the first edge. The bench meets both conditions. It drives bit_i only at falling edges and holds reset low from time zero. It releases reset only at a falling edge, so no bit is ever sampled undefined or at the same moment as reset. The one exception is the bench's R6 check, which toggles bit_i between edges and restores it before the next rising edge.

// File: rtl/altpat_pkg.sv
package altpat_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_HIT  = 2'b01,
    ST_DEAD = 2'b10,
    ST_VOID = 2'b11
  } altpat_state_e;
endpackage

// File: rtl/altpat_next.sv
module altpat_next
  import altpat_pkg::*;
(
  input  altpat_state_e state_i,
  input  logic          bit_i,
  output altpat_state_e state_o
);
  always_comb begin
    unique case (state_i)
      ST_IDLE: state_o = bit_i ? ST_HIT  : ST_DEAD;
      ST_HIT:  state_o = bit_i ? ST_DEAD : ST_IDLE;
      ST_DEAD: state_o = ST_DEAD;
      // unreachable code folds into the sink
      default: state_o = ST_DEAD;
    endcase
  end
endmodule

// File: rtl/altpat_state_reg.sv
module altpat_state_reg #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= RST_VAL;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/altpat_out.sv
module altpat_out
  import altpat_pkg::*;
(
  input  altpat_state_e state_i,
  output logic          accept_o
);
  always_comb accept_o = (state_i == ST_HIT);
endmodule

// File: rtl/alt_pattern_recognizer.sv
module alt_pattern_recognizer
  import altpat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic accept_o
);
  altpat_state_e state_q;
  altpat_state_e state_d;
  logic [STATE_W-1:0] q_raw;

  altpat_next u_next (
    .state_i (state_q),
    .bit_i   (bit_i),
    .state_o (state_d)
  );

  altpat_state_reg #(
    .W       (STATE_W),
    .RST_VAL (ST_IDLE)
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (state_d),
    .q_o    (q_raw)
  );

  assign state_q = altpat_state_e'(q_raw);

  altpat_out u_out (
    .state_i  (state_q),
    .accept_o (accept_o)
  );
endmodule

// File: rtl/alt_pattern_recognizer_chk.sv
module alt_pattern_recognizer_chk
  import altpat_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bit_i,
  input altpat_state_e state_q,
  input logic          accept_o
);
  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (state_q == ST_IDLE && !accept_o));

  p_idle_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q == ($past(bit_i) ? ST_HIT : ST_DEAD)));

  p_hit_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HIT) |=> (state_q == ($past(bit_i) ? ST_DEAD : ST_IDLE)));

  p_dead_sink_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEAD) |=> (state_q == ST_DEAD && !accept_o));

  p_accept_follows_state_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state_q) |-> $stable(accept_o));

  p_no_void_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_VOID);
endmodule

bind alt_pattern_recognizer alt_pattern_recognizer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_i    (bit_i),
  .state_q  (state_q),
  .accept_o (accept_o)
);

// File: tb/tb_alt_pattern_recognizer.sv
module tb_alt_pattern_recognizer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_in = 1'b0;
  logic accept;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference: prefix still alternating, and bits seen
  bit ref_ok;
  int ref_len;

  alt_pattern_recognizer dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .bit_i    (bit_in),
    .accept_o (accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit ref_accept();
    return ref_ok && (ref_len % 2 == 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: accept_o=%b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_in = 1'b0;
    ref_ok = 1'b1;
    ref_len = 0;
    @(negedge clk);
    check("R1", accept, 1'b0);
    rst_n = 1'b1;
  endtask

  // drive one bit at a falling edge, check after the next falling edge
  task automatic step(string req, logic b);
    bit_in = b;
    if (ref_ok && b != ((ref_len % 2) == 0)) ref_ok = 1'b0;
    ref_len++;
    @(negedge clk);
    check(req, accept, ref_accept());
  endtask

  task automatic t_string(string req, logic [15:0] bits, int len);
    do_reset();
    for (int i = len - 1; i >= 0; i--) step(req, bits[i]);
  endtask

  task automatic t_directed();
    t_string("R2", 16'b1, 1);
    t_string("R5", 16'b10101, 5);
    t_string("R3", 16'b100, 3);
    t_string("R3", 16'b11, 2);
    t_string("R2", 16'b0, 1);
    t_string("R3", 16'b10, 2);
  endtask

  task automatic t_sink();
    do_reset();
    step("R4", 1'b0);
    for (int i = 0; i < 8; i++) step("R4", (i % 2) == 0);
    do_reset();
    step("R4", 1'b1);
    step("R4", 1'b1);
    for (int i = 0; i < 6; i++) step("R4", (i % 3) == 1);
  endtask

  task automatic t_async_reset();
    do_reset();
    step("R7", 1'b1);
    step("R7", 1'b0);
    step("R7", 1'b1);
    check("R7", accept, 1'b1);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1", accept, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ref_ok = 1'b1;
    ref_len = 0;
    step("R7", 1'b1);
    step("R7", 1'b0);
    step("R7", 1'b1);
  endtask

  task automatic t_moore();
    do_reset();
    step("R6", 1'b1);
    for (int i = 0; i < 4; i++) begin
      bit_in = ~bit_in;
      #(CLK_PERIOD/8);
      check("R6", accept, 1'b1);
    end
    step("R6", 1'b0);
    for (int i = 0; i < 4; i++) begin
      bit_in = ~bit_in;
      #(CLK_PERIOD/8);
      check("R6", accept, 1'b0);
    end
    step("R6", 1'b1);
  endtask

  task automatic t_random();
    for (int s = 0; s < 40; s++) begin
      do_reset();
      for (int i = 0; i < 24; i++) begin
        logic good;
        good = ((ref_len % 2) == 0);
        step("R5", ($urandom_range(0, 9) < 9) ? good : ~good);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    ref_ok = 1'b1;
    ref_len = 0;
    #1;
    check("R1", accept, 1'b0);
    t_directed();
    t_sink();
    t_async_reset();
    t_moore();
    t_random();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    finish_run();
  end
endmodule